// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Register Loader

This block keeps the two thresholds that a FIFO's almost-empty and almost-full flags are compared against: an empty-side offset and a full-side offset, each as wide as the FIFO's address. The flag comparison itself is done elsewhere. The block only supplies the two values, on its offset outputs.

The level of the configuration-load strobe is sampled while master reset is held. It picks two things at once: the default value given to both offsets (a small or a large preset), and the only write method allowed until the next master reset. The parallel method takes words from the write-data bus. The serial method shifts in a bit stream that covers both registers.

After reset, the same strobe is combined with one of three enables. With the write enable it writes a parallel word, with the serial enable it shifts a serial bit, and with the read enable it reads a register back. A write-side pointer and a separate read-side pointer each alternate between the two registers. Readback is always parallel, whichever write method is locked in. A partial reset clears only the readback word.

Top module: `flag_offset_loader`

## Requirements
- R1: If `cfg_ld_n` is 0 at a `wr_clk` edge with `mrst_n` low, both offsets become DEF_NEAR (127 by default) and the parallel method is locked in.
- R2: If `cfg_ld_n` is 1 at a `wr_clk` edge with `mrst_n` low, both offsets become DEF_FAR (1023 by default) and the serial method is locked in.
- R3: With the parallel method, a `wr_clk` edge where `cfg_ld_n`=0 and `wr_en_n`=0 stores `wr_data[OFS_W-1:0]` into the register that the write pointer selects. The first such write after master reset goes to the empty offset and the next to the full offset, and the pointer keeps alternating.
- R4: With the serial method, a `wr_clk` edge where `cfg_ld_n`=0 and `ser_en_n`=0 shifts the pair {full, empty} one place toward empty bit 0, and `ser_in` enters at full bit OFS_W-1. After 2*OFS_W shifts (28 by default), the first bit sent sits at empty bit 0 and the last at full bit OFS_W-1.
- R5: With the serial method, the offsets hold when `ser_en_n`=1 or `cfg_ld_n`=1.
- R6: A parallel write attempted under the serial method, or a serial shift attempted under the parallel method, leaves both offsets and the write pointer unchanged.
- R7: A `rd_clk` edge where `cfg_ld_n`=0 and `rd_en_n`=0 loads `rd_data` with the offset the read pointer selects, zero-extended. The first read after master reset returns the empty offset and the reads then alternate. This works under either method. With no such edge, `rd_data` holds.
- R8: While `prst_n` is low, the offsets, the method and both pointers do not change, and any write or read strobe is ignored. `rd_data` is cleared to zero at each clock edge where `prst_n` is low.
- R9: Master reset clears `rd_data` to zero and returns both pointers to the empty offset.
- R10: When a parallel write and a readback of the same register happen at one edge of a shared clock, the readback returns the value held before that write.
- R11: Once master reset is released, changes on `cfg_ld_n` never change the locked method.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock (may be the same net as wr_clk) |
| mrst_n | input | 1 | Master reset, active low, sampled on each clock |
| prst_n | input | 1 | Partial reset, active low |
| cfg_ld_n | input | 1 | Load strobe; its level during master reset selects defaults and method |
| wr_en_n | input | 1 | Parallel write enable, active low |
| ser_en_n | input | 1 | Serial shift enable, active low |
| ser_in | input | 1 | Serial data bit |
| rd_en_n | input | 1 | Readback enable, active low |
| wr_data | input | DATA_W | Parallel write word; low OFS_W bits used |
| rd_data | output | DATA_W | Readback word |
| empty_ofs | output | log2(DEPTH) | Empty-side offset |
| full_ofs | output | log2(DEPTH) | Full-side offset |

## Verification
A parallel write and a readback can fall on the same edge when both clocks come from one source. This matters most when both pointers select the same register. The bench drives both clocks from one clock and raises both enables in one cycle, on purpose in a directed case and by chance in the random phase. It then expects `rd_data` to show the old register value while the offset output already shows the new one. Partial reset is also made to land together with write and read strobes, and the bench expects every effect of those strobes to be dropped.

// File: rtl/flag_offset_pkg.sv
package flag_offset_pkg;

   // Write method locked in at master reset
   typedef enum logic {
      LOAD_PARALLEL = 1'b0,
      LOAD_SERIAL   = 1'b1
   } load_mode_e;

   // Register selected by a sequencing pointer
   typedef enum logic {
      SLOT_EMPTY = 1'b0,
      SLOT_FULL  = 1'b1
   } slot_e;

   localparam int NUM_SLOTS = 2;

   function automatic slot_e next_slot(input slot_e cur);
      return (cur == SLOT_EMPTY) ? SLOT_FULL : SLOT_EMPTY;
   endfunction

endpackage

// File: rtl/offset_write_ctrl.sv
module offset_write_ctrl
   import flag_offset_pkg::*;
#(
   parameter int OFS_W    = 14,
   parameter int DATA_W   = 18,
   parameter int DEF_NEAR = 127,
   parameter int DEF_FAR  = 1023
) (
   input  logic              clk,
   input  logic              mrst_n,
   input  logic              prst_n,
   input  logic              ld_n,
   input  logic              wen_n,
   input  logic              sen_n,
   input  logic              ser_bit,
   input  logic [DATA_W-1:0] wdata,
   output logic [OFS_W-1:0]  empty_ofs,
   output logic [OFS_W-1:0]  full_ofs
);

   localparam logic [OFS_W-1:0] NEAR_V = OFS_W'(DEF_NEAR);
   localparam logic [OFS_W-1:0] FAR_V  = OFS_W'(DEF_FAR);

   initial begin
      assert (OFS_W >= 2) else $error("OFS_W must be at least 2");
      assert (DATA_W >= OFS_W) else $error("DATA_W must cover OFS_W");
      assert (DEF_NEAR < (1 << OFS_W)) else $error("DEF_NEAR too wide");
      assert (DEF_FAR < (1 << OFS_W)) else $error("DEF_FAR too wide");
   end

   load_mode_e        mode_q;
   slot_e             wptr_q;
   logic              par_wr;
   logic              ser_sh;
   logic [OFS_W-1:0]  wfield;

   // Strobes, gated by the locked method and by partial reset
   always_comb begin
      par_wr = prst_n && !ld_n && !wen_n && (mode_q == LOAD_PARALLEL);
      ser_sh = prst_n && !ld_n && !sen_n && (mode_q == LOAD_SERIAL);
   end

   // Bus field selection; unused upper bits only exist when the bus is wider
   generate
      if (DATA_W > OFS_W) begin : g_wide_bus
         logic unused_hi_bits;
         assign unused_hi_bits = ^wdata[DATA_W-1:OFS_W];
         assign wfield = wdata[OFS_W-1:0];
      end else begin : g_exact_bus
         assign wfield = wdata;
      end
   endgenerate

   // Method latch and write sequencing pointer
   always_ff @(posedge clk) begin
      if (!mrst_n) begin
         mode_q <= ld_n ? LOAD_SERIAL : LOAD_PARALLEL;
         wptr_q <= SLOT_EMPTY;
      end else if (par_wr) begin
         wptr_q <= next_slot(wptr_q);
      end
   end

   // One register per slot; the serial chain runs full -> empty
   generate
      for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
         logic [OFS_W-1:0] val_q;
         logic             chain_in;

         if (i == NUM_SLOTS - 1) begin : g_head
            assign chain_in = ser_bit;
         end else begin : g_link
            assign chain_in = g_slot[i+1].val_q[0];
         end

         always_ff @(posedge clk) begin
            if (!mrst_n)
               val_q <= ld_n ? FAR_V : NEAR_V;
            else if (par_wr && (wptr_q == slot_e'(i)))
               val_q <= wfield;
            else if (ser_sh)
               val_q <= {chain_in, val_q[OFS_W-1:1]};
         end
      end
   endgenerate

   assign empty_ofs = g_slot[0].val_q;
   assign full_ofs  = g_slot[1].val_q;

   // R8
   prst_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      !prst_n |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(wptr_q)));

   // R11
   mode_lock_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      mrst_n |=> $stable(mode_q));

   // R6
   ser_in_par_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      (mode_q == LOAD_PARALLEL && !ld_n && !sen_n && wen_n)
      |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(wptr_q)));

   // R6
   par_in_ser_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      (mode_q == LOAD_SERIAL && !ld_n && !wen_n && sen_n)
      |=> ($stable(empty_ofs) && $stable(full_ofs) && $stable(wptr_q)));

   // R3
   wptr_step_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      (mode_q == LOAD_PARALLEL && prst_n && !ld_n && !wen_n)
      |=> (wptr_q != $past(wptr_q)));

   // R5
   ser_idle_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      (mode_q == LOAD_SERIAL && (sen_n || ld_n))
      |=> ($stable(empty_ofs) && $stable(full_ofs)));

endmodule

// File: rtl/offset_readback.sv
module offset_readback
   import flag_offset_pkg::*;
#(
   parameter int OFS_W  = 14,
   parameter int DATA_W = 18
) (
   input  logic              clk,
   input  logic              mrst_n,
   input  logic              prst_n,
   input  logic              ld_n,
   input  logic              ren_n,
   input  logic [OFS_W-1:0]  empty_ofs,
   input  logic [OFS_W-1:0]  full_ofs,
   output logic [DATA_W-1:0] rdata
);

   slot_e             rptr_q;
   logic              rd_go;
   logic [OFS_W-1:0]  sel_ofs;
   logic [DATA_W-1:0] sel_ext;

   always_comb begin
      rd_go   = prst_n && !ld_n && !ren_n;
      sel_ofs = (rptr_q == SLOT_FULL) ? full_ofs : empty_ofs;
   end

   generate
      if (DATA_W > OFS_W) begin : g_pad
         assign sel_ext = {{(DATA_W-OFS_W){1'b0}}, sel_ofs};
      end else begin : g_nopad
         assign sel_ext = sel_ofs;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!mrst_n) begin
         rptr_q <= SLOT_EMPTY;
         rdata  <= '0;
      end else if (!prst_n) begin
         rdata  <= '0;
      end else if (rd_go) begin
         rdata  <= sel_ext;
         rptr_q <= next_slot(rptr_q);
      end
   end

   // R8
   prst_clear_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      !prst_n |=> (rdata == '0));

   // R7
   rptr_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      (ld_n || ren_n || !prst_n) |=> $stable(rptr_q));

   // R7
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      (prst_n && (ld_n || ren_n)) |=> $stable(rdata));

   // R7
   rptr_step_chk: assert property (@(posedge clk) disable iff (!mrst_n)
      (prst_n && !ld_n && !ren_n) |=> (rptr_q != $past(rptr_q)));

endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
   import flag_offset_pkg::*;
#(
   parameter int DEPTH    = 16384,
   parameter int DATA_W   = 18,
   parameter int DEF_NEAR = 127,
   parameter int DEF_FAR  = 1023
) (
   input  logic                      wr_clk,
   input  logic                      rd_clk,
   input  logic                      mrst_n,
   input  logic                      prst_n,
   input  logic                      cfg_ld_n,
   input  logic                      wr_en_n,
   input  logic                      ser_en_n,
   input  logic                      ser_in,
   input  logic                      rd_en_n,
   input  logic [DATA_W-1:0]         wr_data,
   output logic [DATA_W-1:0]         rd_data,
   output logic [$clog2(DEPTH)-1:0]  empty_ofs,
   output logic [$clog2(DEPTH)-1:0]  full_ofs
);

   localparam int OFS_W = $clog2(DEPTH);

   initial begin
      assert ((1 << OFS_W) == DEPTH) else $error("DEPTH must be a power of two");
   end

   offset_write_ctrl #(
      .OFS_W    (OFS_W),
      .DATA_W   (DATA_W),
      .DEF_NEAR (DEF_NEAR),
      .DEF_FAR  (DEF_FAR)
   ) u_wr (
      .clk       (wr_clk),
      .mrst_n    (mrst_n),
      .prst_n    (prst_n),
      .ld_n      (cfg_ld_n),
      .wen_n     (wr_en_n),
      .sen_n     (ser_en_n),
      .ser_bit   (ser_in),
      .wdata     (wr_data),
      .empty_ofs (empty_ofs),
      .full_ofs  (full_ofs)
   );

   offset_readback #(
      .OFS_W  (OFS_W),
      .DATA_W (DATA_W)
   ) u_rd (
      .clk       (rd_clk),
      .mrst_n    (mrst_n),
      .prst_n    (prst_n),
      .ld_n      (cfg_ld_n),
      .ren_n     (rd_en_n),
      .empty_ofs (empty_ofs),
      .full_ofs  (full_ofs),
      .rdata     (rd_data)
   );

endmodule

// File: tb/flag_offset_loader_bench.sv
module flag_offset_loader_bench;
   localparam int DEPTH = 16384;
   localparam int DW    = 18;
   localparam int OW    = 14;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic mrst_n, prst_n, cfg_ld_n, wr_en_n, ser_en_n, ser_in, rd_en_n;
   logic [DW-1:0] wr_data, rd_data;
   logic [OW-1:0] empty_ofs, full_ofs;

   flag_offset_loader u_flag_offset_loader (
      .wr_clk(clk), .rd_clk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
      .cfg_ld_n(cfg_ld_n), .wr_en_n(wr_en_n), .ser_en_n(ser_en_n),
      .ser_in(ser_in), .rd_en_n(rd_en_n), .wr_data(wr_data),
      .rd_data(rd_data), .empty_ofs(empty_ofs), .full_ofs(full_ofs)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [OW-1:0] m_e, m_f;
   bit            m_ser, m_wp, m_rp;
   logic [DW-1:0] m_rd;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [OW-1:0] dflt(input logic ld);
      return ld ? OW'(1023) : OW'(127);
   endfunction

   // Next model state from the inputs currently driven
   task automatic model_step();
      logic [2*OW-1:0] pair;
      logic [OW-1:0]   old_e, old_f;
      old_e = m_e; old_f = m_f;
      if (!mrst_n) begin
         m_e = dflt(cfg_ld_n); m_f = dflt(cfg_ld_n);
         m_ser = cfg_ld_n; m_wp = 0; m_rp = 0; m_rd = '0;
      end else if (!prst_n) begin
         m_rd = '0;
      end else begin
         if (!cfg_ld_n && !wr_en_n && !m_ser) begin
            if (m_wp) m_f = wr_data[OW-1:0]; else m_e = wr_data[OW-1:0];
            m_wp = !m_wp;
         end
         if (!cfg_ld_n && !ser_en_n && m_ser) begin
            pair = {ser_in, old_f, old_e[OW-1:1]};
            m_f = pair[2*OW-1:OW]; m_e = pair[OW-1:0];
         end
         if (!cfg_ld_n && !rd_en_n) begin
            m_rd = DW'(m_rp ? old_f : old_e);
            m_rp = !m_rp;
         end
      end
   endtask

   task automatic cyc(input logic mr, pr, ld, wen, sen, si, ren,
                      input logic [DW-1:0] din);
      mrst_n = mr; prst_n = pr; cfg_ld_n = ld; wr_en_n = wen;
      ser_en_n = sen; ser_in = si; rd_en_n = ren; wr_data = din;
      model_step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check_all(string tag);
      chk({tag, " empty_ofs"}, 32'(empty_ofs), 32'(m_e));
      chk({tag, " full_ofs"},  32'(full_ofs),  32'(m_f));
      chk({tag, " rd_data"},   32'(rd_data),   32'(m_rd));
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      logic [2*OW-1:0] pat;
      int unsigned seed_set;
      seed_set = $urandom(32'd20240611);
      @(negedge clk);

      // R1 R9: master reset, load strobe low
      cyc(0,1,0,1,1,0,1,'0);
      cyc(0,1,0,1,1,0,1,'0);
      chk("R1 empty default", 32'(empty_ofs), 32'd127);
      chk("R1 full default",  32'(full_ofs),  32'd127);
      chk("R9 rd_data cleared", 32'(rd_data), 32'd0);

      // R11: load strobe high alone after reset, method stays parallel
      cyc(1,1,1,1,1,0,1,'0);
      cyc(1,1,1,0,1,0,1,18'h0_0123);
      check_all("R11 idle");

      // R3: parallel writes, upper bus bits dropped
      cyc(1,1,0,0,1,0,1,18'h3_1555);
      chk("R3 first write to empty", 32'(empty_ofs), 32'h1555);
      cyc(1,1,0,0,1,0,1,18'h0_2AAA);
      chk("R3 second write to full", 32'(full_ofs), 32'h2AAA);
      check_all("R3");
      cyc(1,1,1,1,1,0,1,'0);
      cyc(1,1,0,1,0,1,1,'0);
      check_all("R11 parallel still active");

      // R6: serial shift under parallel method
      cyc(1,1,0,1,0,1,1,'0);
      cyc(1,1,0,1,0,0,1,'0);
      check_all("R6 serial ignored");

      // R10: write and readback of empty offset on one edge
      cyc(1,1,0,0,1,0,0,18'h0_0777);
      chk("R10 readback old value", 32'(rd_data), 32'h1555);
      chk("R10 new value stored", 32'(empty_ofs), 32'h0777);

      // R7: next read returns full offset
      cyc(1,1,0,1,1,0,0,'0);
      chk("R7 second read full", 32'(rd_data), 32'h2AAA);
      cyc(1,1,0,1,1,0,1,'0);
      check_all("R7 hold");

      // R8: partial reset with strobes active
      cyc(1,0,0,0,1,0,0,18'h0_0055);
      chk("R8 rd_data cleared", 32'(rd_data), 32'd0);
      check_all("R8 during");
      cyc(1,1,0,0,1,0,1,18'h0_1111);
      chk("R8 pointer kept, write to full", 32'(full_ofs), 32'h1111);
      cyc(1,1,0,1,1,0,0,'0);
      chk("R8 read pointer kept", 32'(rd_data), 32'h0777);

      // R2: master reset, load strobe high
      cyc(0,1,1,1,1,0,1,'0);
      chk("R2 empty default", 32'(empty_ofs), 32'd1023);
      chk("R2 full default",  32'(full_ofs),  32'd1023);

      // R6: parallel write under serial method
      cyc(1,1,0,0,1,0,1,18'h0_0042);
      check_all("R6 parallel ignored");

      // R4: full serial stream
      pat = {14'h2ABC, 14'h1234};
      for (int k = 0; k < 2*OW; k++) begin
         cyc(1,1,0,1,0,pat[k],1,'0);
         if (k == OW - 1) check_all("R4 half stream");
      end
      chk("R4 empty from stream", 32'(empty_ofs), 32'h1234);
      chk("R4 full from stream",  32'(full_ofs),  32'h2ABC);

      // R5: holds with serial enable high or load strobe high
      cyc(1,1,0,1,1,1,1,'0);
      cyc(1,1,1,1,0,1,1,'0);
      chk("R5 empty held", 32'(empty_ofs), 32'h1234);
      chk("R5 full held",  32'(full_ofs),  32'h2ABC);

      // R7 R9: readback under serial method starts at empty
      cyc(1,1,0,1,1,0,0,'0);
      chk("R7 R9 serial read empty", 32'(rd_data), 32'h1234);
      cyc(1,1,0,1,1,0,0,'0);
      chk("R7 serial read full", 32'(rd_data), 32'h2ABC);

      // Random phase covering R3 R4 R5 R6 R7 R8 R10
      for (int n = 0; n < 800; n++) begin
         cyc(($urandom % 64) != 0, ($urandom % 32) != 0,
             ($urandom % 4) == 0, $urandom % 2, $urandom % 2,
             $urandom % 2, $urandom % 2, DW'($urandom));
         check_all("R3/R4/R7/R8 random");
      end

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule